// File: doc/BRIEF.md
# River-Crossing Trip Referee

This block referees the classic three-missionary, three-cannibal river-crossing puzzle. It keeps the number of missionaries and cannibals still on the starting (left) bank and the side the boat is on. Each cycle a proposed trip may be offered, given as the number of missionaries and cannibals riding in the boat. The block checks the trip against the puzzle rules. A legal trip updates the bank counts and sends the boat across. An illegal trip leaves the state alone and raises an error pulse. A done flag marks the solved position.

The trip input is a valid-qualified request with no back-pressure. The referee can take a decision in every cycle, so it has no ready signal. A request counts in the cycle where `move_valid` is high at a rising clock edge. Its verdict appears as a one-cycle `accept` or `error` pulse in the following cycle, together with the updated state. Searching for a solution is left to whatever drives the block.

Top module: `rc_crossing_referee`

## Requirements
- R1: While `rst` is high (asynchronous, active high), the left bank holds 3 missionaries and 3 cannibals and `boat_side` is 0 (left). `accept`, `error` and `done` are all 0.
- R2: A trip is rejected unless it carries at least one and at most two people in total (`move_m + move_c` in 1..2).
- R3: An accepted trip subtracts the carried counts from the left bank when `boat_side` is 0, and adds them when it is 1. It toggles `boat_side` and pulses `accept` for one cycle. All of this is visible in the cycle after the request.
- R4: A trip is rejected if, afterwards, a bank holding at least one missionary has more cannibals than missionaries. A bank with no missionaries is always safe.
- R5: A rejected trip pulses `error` for one cycle, in the cycle after the request. The bank counts and `boat_side` stay unchanged.
- R6: A trip is rejected if it takes more missionaries or more cannibals than are present on the bank the boat is leaving.
- R7: `done` is 1 exactly when the left bank is empty and `boat_side` is 1. While `done` is 1, every trip is rejected until reset.
- R8: A cycle with `move_valid` low changes no state and produces neither `accept` nor `error`.
- R9: Starting from reset, the eleven-trip solution is accepted trip by trip and ends with `done` at 1. The trips are given as (missionaries, cannibals): (0,2) (0,1) (0,2) (0,1) (2,0) (1,1) (2,0) (0,1) (0,2) (0,1) (0,2).
- R10: `accept` and `error` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous active-high reset |
| move_valid | input | 1 | A trip is offered this cycle |
| move_m | input | 2 | Missionaries carried by the trip |
| move_c | input | 2 | Cannibals carried by the trip |
| left_m | output | 2 | Missionaries on the left bank |
| left_c | output | 2 | Cannibals on the left bank |
| boat_side | output | 1 | Boat position, 0 left, 1 right |
| accept | output | 1 | Previous request was legal and applied |
| error | output | 1 | Previous request was illegal and ignored |
| done | output | 1 | Everyone is on the right bank |

## Verification
The bench uses the default parameters: three of each kind and a boat for two. With these values the eleven-trip solution and every unsafe bank split can be reached with two-bit trip fields. A trip field value of 3 also exercises the capacity limit beyond the plain sum of two. The rejection cases are placed at specific positions along the solution path: an unsafe split from the start, a return trip from a bank that has no missionaries, and moves offered after the puzzle is solved. This lets the behavioural model catch a state that changed when it should not have.

// File: rtl/rc_pkg.sv
package rc_pkg;
  typedef enum logic {
    SIDE_LEFT  = 1'b0,
    SIDE_RIGHT = 1'b1
  } side_e;

  function automatic int unsigned rc_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/rc_trip_rules.sv
module rc_trip_rules #(
  parameter int unsigned NUM_M = 3,
  parameter int unsigned NUM_C = 3,
  parameter int unsigned CAP   = 2,
  parameter int unsigned CW    = 2
) (
  input  logic          side,
  input  logic [CW-1:0] bank_m,
  input  logic [CW-1:0] bank_c,
  input  logic [CW-1:0] trip_m,
  input  logic [CW-1:0] trip_c,
  output logic          legal,
  output logic [CW-1:0] nxt_m,
  output logic [CW-1:0] nxt_c
);
  localparam int unsigned EW = CW + 1;
  localparam logic [EW-1:0] TOT_M = EW'(NUM_M);
  localparam logic [EW-1:0] TOT_C = EW'(NUM_C);
  localparam logic [EW-1:0] LOAD_MAX = EW'(CAP);

  logic [EW-1:0] lm, lc, rm, rc, tm, tc, load;
  logic [EW-1:0] src_m, src_c, nl_m, nl_c, nr_m, nr_c;
  logic cap_ok, avail_ok, left_safe, right_safe;

  always_comb begin
    lm = {1'b0, bank_m};
    lc = {1'b0, bank_c};
    tm = {1'b0, trip_m};
    tc = {1'b0, trip_c};
    rm = TOT_M - lm;
    rc = TOT_C - lc;
    load = tm + tc;
    src_m = side ? rm : lm;
    src_c = side ? rc : lc;
    cap_ok = (load != '0) && (load <= LOAD_MAX);
    avail_ok = (tm <= src_m) && (tc <= src_c);
    nl_m = side ? (lm + tm) : (lm - tm);
    nl_c = side ? (lc + tc) : (lc - tc);
    nr_m = TOT_M - nl_m;
    nr_c = TOT_C - nl_c;
    left_safe  = (nl_m == '0) || (nl_c <= nl_m);
    right_safe = (nr_m == '0) || (nr_c <= nr_m);
    legal = cap_ok && avail_ok && left_safe && right_safe;
    nxt_m = nl_m[CW-1:0];
    nxt_c = nl_c[CW-1:0];
  end
endmodule

// File: rtl/rc_bank_state.sv
module rc_bank_state #(
  parameter int unsigned NUM_M = 3,
  parameter int unsigned NUM_C = 3,
  parameter int unsigned CW    = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          commit,
  input  logic [CW-1:0] nxt_m,
  input  logic [CW-1:0] nxt_c,
  output logic [CW-1:0] cur_m,
  output logic [CW-1:0] cur_c,
  output rc_pkg::side_e cur_side
);
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      cur_m    <= CW'(NUM_M);
      cur_c    <= CW'(NUM_C);
      cur_side <= rc_pkg::SIDE_LEFT;
    end else if (commit) begin
      cur_m    <= nxt_m;
      cur_c    <= nxt_c;
      cur_side <= (cur_side == rc_pkg::SIDE_LEFT) ? rc_pkg::SIDE_RIGHT : rc_pkg::SIDE_LEFT;
    end
  end
endmodule

// File: rtl/rc_crossing_referee.sv
module rc_crossing_referee #(
  parameter int unsigned NUM_M = 3,
  parameter int unsigned NUM_C = 3,
  parameter int unsigned CAP   = 2,
  parameter int unsigned CW    = $clog2(rc_pkg::rc_max(NUM_M, NUM_C) + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          move_valid,
  input  logic [CW-1:0] move_m,
  input  logic [CW-1:0] move_c,
  output logic [CW-1:0] left_m,
  output logic [CW-1:0] left_c,
  output logic          boat_side,
  output logic          accept,
  output logic          error,
  output logic          done
);
  rc_pkg::side_e side_q;
  logic          legal, take;
  logic [CW-1:0] nxt_m, nxt_c;

  rc_trip_rules #(.NUM_M(NUM_M), .NUM_C(NUM_C), .CAP(CAP), .CW(CW)) u_rules (
    .side   (side_q == rc_pkg::SIDE_RIGHT),
    .bank_m (left_m),
    .bank_c (left_c),
    .trip_m (move_m),
    .trip_c (move_c),
    .legal  (legal),
    .nxt_m  (nxt_m),
    .nxt_c  (nxt_c)
  );

  assign done = (left_m == '0) && (left_c == '0) && (side_q == rc_pkg::SIDE_RIGHT);
  assign take = move_valid && legal && !done;
  assign boat_side = (side_q == rc_pkg::SIDE_RIGHT);

  rc_bank_state #(.NUM_M(NUM_M), .NUM_C(NUM_C), .CW(CW)) u_state (
    .clk      (clk),
    .rst      (rst),
    .commit   (take),
    .nxt_m    (nxt_m),
    .nxt_c    (nxt_c),
    .cur_m    (left_m),
    .cur_c    (left_c),
    .cur_side (side_q)
  );

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      accept <= 1'b0;
      error  <= 1'b0;
    end else begin
      accept <= take;
      error  <= move_valid && !take;
    end
  end
endmodule

// File: rtl/rc_referee_checker.sv
module rc_referee_checker #(
  parameter int unsigned NUM_M = 3,
  parameter int unsigned NUM_C = 3,
  parameter int unsigned CW    = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          move_valid,
  input logic [CW-1:0] left_m,
  input logic [CW-1:0] left_c,
  input logic          boat_side,
  input logic          accept,
  input logic          error,
  input logic          done
);
  localparam int unsigned EW = CW + 1;
  logic [EW-1:0] rgt_m, rgt_c;
  assign rgt_m = EW'(NUM_M) - {1'b0, left_m};
  assign rgt_c = EW'(NUM_C) - {1'b0, left_c};

  // R3: every accepted trip moves the boat
  p_side_flip_r3: assert property (@(posedge clk) disable iff (rst)
    accept |-> (boat_side != $past(boat_side)));

  // R5: a rejected trip leaves the banks and the boat alone
  p_reject_hold_r5: assert property (@(posedge clk) disable iff (rst)
    error |-> ($stable(left_m) && $stable(left_c) && $stable(boat_side)));

  // R8: no verdict without a request
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(move_valid) |-> (!accept && !error));

  // R10: verdicts are exclusive
  p_one_verdict_r10: assert property (@(posedge clk) disable iff (rst)
    !(accept && error));

  // R4: the held state is always safe on both banks
  p_banks_safe_r4: assert property (@(posedge clk) disable iff (rst)
    ((left_m == '0) || (left_c <= left_m)) && ((rgt_m == '0) || (rgt_c <= rgt_m)));

  // R7: solved position is frozen
  p_done_frozen_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> (done && !accept));
endmodule

bind rc_crossing_referee rc_referee_checker #(.NUM_M(NUM_M), .NUM_C(NUM_C), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .move_valid(move_valid), .left_m(left_m), .left_c(left_c),
  .boat_side(boat_side), .accept(accept), .error(error), .done(done)
);

// File: tb/test_rc_crossing_referee.sv
module test_rc_crossing_referee;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic move_valid = 1'b0;
  logic [1:0] move_m = '0, move_c = '0;
  logic [1:0] left_m, left_c;
  logic boat_side, accept, error, done;

  int checks = 0, errors = 0;
  int lm = 3, lc = 3, sd = 0, acc = 0, err = 0;

  always #2 clk = ~clk;

  rc_crossing_referee i_rc_crossing_referee (
    .clk(clk), .rst(rst), .move_valid(move_valid), .move_m(move_m), .move_c(move_c),
    .left_m(left_m), .left_c(left_c), .boat_side(boat_side),
    .accept(accept), .error(error), .done(done)
  );

  function automatic bit ok_bank(int m, int c);
    return (m == 0) || (c <= m);
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    int dn;
    dn = (lm == 0 && lc == 0 && sd == 1) ? 1 : 0;
    check(tag, "left_m", int'(left_m), lm);
    check(tag, "left_c", int'(left_c), lc);
    check(tag, "boat_side", int'(boat_side), sd);
    check(tag, "accept", int'(accept), acc);
    check(tag, "error", int'(error), err);
    check(tag, "done", int'(done), dn);
  endtask

  // one clock: drive at negedge, model the rising edge, compare at next negedge
  task automatic step(string tag, bit v, int m, int c);
    int nm, nc, solved;
    bit legal;
    move_valid = v; move_m = 2'(m); move_c = 2'(c);
    @(negedge clk);
    solved = (lm == 0 && lc == 0 && sd == 1) ? 1 : 0;
    nm = (sd == 0) ? lm - m : lm + m;
    nc = (sd == 0) ? lc - c : lc + c;
    legal = (m + c >= 1) && (m + c <= 2) && (nm >= 0) && (nm <= 3) && (nc >= 0) && (nc <= 3)
            && ok_bank(nm, nc) && ok_bank(3 - nm, 3 - nc) && (solved == 0);
    acc = (v && legal) ? 1 : 0;
    err = (v && !legal) ? 1 : 0;
    if (v && legal) begin lm = nm; lc = nc; sd = 1 - sd; end
    compare(tag);
  endtask

  task automatic solve_all();
    step("R9", 1, 0, 2); step("R9", 1, 0, 1); step("R9", 1, 0, 2);
    step("R9", 1, 0, 1); step("R9", 1, 2, 0); step("R9", 1, 1, 1);
    step("R9", 1, 2, 0); step("R9", 1, 0, 1); step("R9", 1, 0, 2);
    step("R9", 1, 0, 1); step("R9", 1, 0, 2);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1");                       // reset values while rst held
    rst = 1'b0;
    step("R8", 0, 2, 0);                 // idle with junk on the fields
    step("R2", 1, 0, 0);                 // empty boat
    step("R2", 1, 2, 1);                 // three aboard
    step("R2", 1, 3, 0);                 // field beyond capacity
    step("R4", 1, 1, 0);                 // leaves 2M 3C on the left
    step("R4", 1, 2, 0);                 // leaves 1M 3C on the left
    step("R3", 1, 1, 1);                 // legal first trip
    step("R6", 1, 2, 0);                 // only 1 missionary on the right
    step("R3", 1, 1, 0);                 // bring him back
    step("R8", 0, 0, 0);
    // restart and solve
    rst = 1'b1; lm = 3; lc = 3; sd = 0; acc = 0; err = 0;
    @(negedge clk);
    compare("R1");
    rst = 1'b0;
    solve_all();
    check("R9", "done after eleventh trip", int'(done), 1);
    step("R7", 1, 0, 1);                 // rejected once solved
    step("R7", 1, 1, 1);
    step("R8", 0, 0, 1);
    check("R7", "done held", int'(done), 1);
    // asynchronous reset between edges
    #1 rst = 1'b1;
    #0.5;
    lm = 3; lc = 3; sd = 0; acc = 0; err = 0;
    check("R1", "async left_m", int'(left_m), 3);
    check("R1", "async boat_side", int'(boat_side), 0);
    check("R1", "async done", int'(done), 0);
    @(negedge clk);
    rst = 1'b0;
    step("R3", 1, 0, 2);
    step("R6", 1, 0, 3);                 // also over capacity
    step("R5", 1, 1, 0);                 // would take a missing missionary back
    step("R3", 1, 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule